// File: doc/BRIEF.md
# Toggle-Acknowledged Error Interrupt Controller

This block tracks global error conditions and raises wired interrupts as single-cycle pulses. Errors are held in two registers of equal width: an error register written only by the hardware and an acknowledge register written only by software. A bit is pending while the two registers disagree in that position. A hardware raise request flips only those bits of the error register that are not pending already. Software acknowledges an error by flipping the matching acknowledge bit, so the two registers agree again.

Three interrupt lines leave the block. The error line fires when a raise request creates at least one new pending bit and the error enable is set. The event-queue line fires on its strobe when its enable is set. The command-sync line fires on every strobe of its own. A strobe for the priority-request queue is accepted but not supported: it raises no line and sets a sticky flag instead. A second sticky flag records acknowledge writes that flipped bits that were not pending.

Software reaches the registers through a plain valid/write/address/data port that has no back-pressure. Every access is taken in the cycle it is presented, and read data comes back combinationally in that same cycle.

Top module: `tae_irq_ctrl`

## Requirements
- R1: After reset the error, acknowledge and control registers read 0, both sticky flags are 0 and no interrupt line is high.
- R2: A bit is pending when the error and acknowledge registers differ in it. When raise_vld is high, the error register is flipped by raise_mask AND NOT pending, and the new value reads back from the next cycle on.
- R3: A raise request whose mask holds only pending bits leaves the error register unchanged and produces no pulse on irq_err.
- R4: irq_err is high for exactly the one cycle after a raise request that flipped at least one bit, and only if control bit 0 (error enable) was 1 before that clock edge.
- R5: A write to the acknowledge register (address 1) stores reg_wdata exactly as written. Writes to the error register (address 0) have no effect.
- R6: stat_stray_ack is set, and stays set until reset, when an acknowledge write flips a bit that is not pending. Pending here is judged after any raise in the same cycle. The acknowledge value is still stored.
- R7: irq_evq is high for one cycle after evq_req only if control bit 1 (event-queue enable) was 1 before that edge.
- R8: irq_sync is high for one cycle after every sync_req, whatever the control register holds.
- R9: prq_req never produces a pulse. It sets stat_unimpl, which stays set until reset.
- R10: When a raise request and an acknowledge write arrive in the same cycle, the raise is evaluated against the acknowledge value from before the write.
- R11: Register map: address 0 is the error register, 1 the acknowledge register, 2 the control register (bits [1:0] are stored, the other bits read 0), and 3 reads 0. reg_rdata follows reg_addr in the same cycle while reg_vld is high and reg_wr is low, and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_vld | input | 1 | Error-raise request strobe |
| raise_mask | input | 32 | Error bits asked to be raised |
| evq_req | input | 1 | Event-queue interrupt request |
| sync_req | input | 1 | Command-sync interrupt request |
| prq_req | input | 1 | Priority-request-queue interrupt request (unsupported) |
| reg_vld | input | 1 | Register access valid |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| irq_err | output | 1 | Error interrupt pulse |
| irq_evq | output | 1 | Event-queue interrupt pulse |
| irq_sync | output | 1 | Command-sync interrupt pulse |
| stat_stray_ack | output | 1 | Sticky flag: an acknowledge write flipped a bit that was not pending |
| stat_unimpl | output | 1 | Sticky flag: an unsupported request was seen |

## Verification
The raise path is tested with masks of three kinds: masks that are all new, masks that only partly overlap pending bits, and masks that fall entirely on pending bits. Together these separate "flip the new bits" from "flip the whole mask" and from "pulse on any request". Acknowledge writes are tested both with flips confined to pending bits and with flips of bits that are not pending, which shows whether stray flips are stored anyway and flagged. A raise and an acknowledge write issued in the same cycle check the ordering rule. The enables are cleared and set one by one to show which lines they gate and that command-sync ignores them. A final random phase mixes all of these inputs and compares every cycle against the reference model.

// File: rtl/tae_pkg.sv
package tae_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = 2;
  localparam int CTRL_ERR_EN = 0;
  localparam int CTRL_EVQ_EN = 1;
  localparam int NUM_SRC = 3;
  localparam int SRC_ERR = 0;
  localparam int SRC_EVQ = 1;
  localparam int SRC_SYNC = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_ERR  = 2'd0,
    RA_ACK  = 2'd1,
    RA_CTRL = 2'd2,
    RA_RSVD = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tae_err_core.sv
module tae_err_core #(
  parameter int ERR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raise_vld,
  input  logic [ERR_W-1:0] raise_mask,
  input  logic             ack_we,
  input  logic [ERR_W-1:0] ack_wdata,
  output logic [ERR_W-1:0] err_q,
  output logic [ERR_W-1:0] ack_q,
  output logic             fresh_any,
  output logic             stray_flag
);
  logic [ERR_W-1:0] pend_now, fresh, err_nxt, pend_after, stray;

  always_comb begin
    pend_now   = err_q ^ ack_q;
    fresh      = raise_mask & ~pend_now;
    err_nxt    = raise_vld ? (err_q ^ fresh) : err_q;
    fresh_any  = raise_vld && (|fresh);
    pend_after = err_nxt ^ ack_q;
    stray      = (ack_wdata ^ ack_q) & ~pend_after;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q      <= '0;
      ack_q      <= '0;
      stray_flag <= 1'b0;
    end else begin
      err_q <= err_nxt;
      if (ack_we) begin
        ack_q <= ack_wdata;
        if (|stray) stray_flag <= 1'b1;
      end
    end
  end

  // R2
  err_only_on_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(raise_vld) |-> $stable(err_q));

  // R2
  err_flips_not_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(raise_vld) |->
      (((err_q ^ $past(err_q)) & ($past(err_q) ^ $past(ack_q))) == '0));

  // R5
  ack_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ack_we) |-> (ack_q == $past(ack_wdata)));

  // R6
  stray_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stray_flag) |-> stray_flag);
endmodule

// File: rtl/tae_regfile.sv
module tae_regfile
  import tae_pkg::*;
#(
  parameter int ERR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_vld,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [ERR_W-1:0]  err_q,
  input  logic [ERR_W-1:0]  ack_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              ack_we,
  output logic [ERR_W-1:0]  ack_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic ctrl_we, rd_en;

  always_comb begin
    ack_we    = reg_vld && reg_wr && (reg_addr == RA_ACK);
    ctrl_we   = reg_vld && reg_wr && (reg_addr == RA_CTRL);
    ack_wdata = reg_wdata[ERR_W-1:0];
    rd_en     = reg_vld && !reg_wr;
    reg_rdata = '0;
    if (rd_en) begin
      case (reg_addr)
        RA_ERR:  reg_rdata = DATA_W'(err_q);
        RA_ACK:  reg_rdata = DATA_W'(ack_q);
        RA_CTRL: reg_rdata = DATA_W'(ctrl_q);
        default: reg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= reg_wdata[CTRL_W-1:0];
  end

  // R11
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_rdata) |-> (reg_vld && !reg_wr));

  // R11
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctrl_we) |-> $stable(ctrl_q));
endmodule

// File: rtl/tae_pulse_gen.sv
module tae_pulse_gen #(
  parameter int N = 3,
  parameter logic [N-1:0] ALWAYS_ON = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] en,
  output logic [N-1:0] pulse
);
  for (genvar i = 0; i < N; i++) begin : g_line
    if (ALWAYS_ON[i]) begin : g_free
      always_ff @(posedge clk) begin
        if (!rst_n) pulse[i] <= 1'b0;
        else pulse[i] <= req[i];
      end
    end else begin : g_gated
      always_ff @(posedge clk) begin
        if (!rst_n) pulse[i] <= 1'b0;
        else pulse[i] <= req[i] && en[i];
      end
    end

    // R4 R7 R8
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[i] |-> $past(req[i]));
  end
endmodule

// File: rtl/tae_irq_ctrl.sv
module tae_irq_ctrl
  import tae_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raise_vld,
  input  logic [DATA_W-1:0] raise_mask,
  input  logic              evq_req,
  input  logic              sync_req,
  input  logic              prq_req,
  input  logic              reg_vld,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_err,
  output logic              irq_evq,
  output logic              irq_sync,
  output logic              stat_stray_ack,
  output logic              stat_unimpl
);
  localparam int ERR_W = DATA_W;
  localparam logic [NUM_SRC-1:0] FREE_LINES = NUM_SRC'(1) << SRC_SYNC;

  logic [ERR_W-1:0]   err_q, ack_q, ack_wdata;
  logic               ack_we, fresh_any;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [NUM_SRC-1:0] req_v, en_v, pulse_v;

  tae_err_core #(.ERR_W(ERR_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .raise_vld(raise_vld), .raise_mask(raise_mask),
    .ack_we(ack_we), .ack_wdata(ack_wdata),
    .err_q(err_q), .ack_q(ack_q),
    .fresh_any(fresh_any), .stray_flag(stat_stray_ack)
  );

  tae_regfile #(.ERR_W(ERR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_vld(reg_vld), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .err_q(err_q), .ack_q(ack_q),
    .ctrl_q(ctrl_q), .ack_we(ack_we), .ack_wdata(ack_wdata),
    .reg_rdata(reg_rdata)
  );

  always_comb begin
    req_v = '0;
    en_v  = '0;
    req_v[SRC_ERR]  = fresh_any;
    req_v[SRC_EVQ]  = evq_req;
    req_v[SRC_SYNC] = sync_req;
    en_v[SRC_ERR]   = ctrl_q[CTRL_ERR_EN];
    en_v[SRC_EVQ]   = ctrl_q[CTRL_EVQ_EN];
  end

  tae_pulse_gen #(.N(NUM_SRC), .ALWAYS_ON(FREE_LINES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .req(req_v), .en(en_v), .pulse(pulse_v)
  );

  assign irq_err  = pulse_v[SRC_ERR];
  assign irq_evq  = pulse_v[SRC_EVQ];
  assign irq_sync = pulse_v[SRC_SYNC];

  always_ff @(posedge clk) begin
    if (!rst_n) stat_unimpl <= 1'b0;
    else if (prq_req) stat_unimpl <= 1'b1;
  end

  // R9
  unimpl_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_unimpl) |-> $past(prq_req));

  // R8
  sync_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_req) |-> irq_sync);

  // R7
  evq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evq |-> $past(ctrl_q[CTRL_EVQ_EN]));

  // R4
  err_irq_changes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (err_q != $past(err_q)));
endmodule

// File: tb/tb_tae_irq_ctrl.sv
module tb_tae_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raise_vld = 1'b0;
  logic [31:0] raise_mask = '0;
  logic evq_req = 1'b0, sync_req = 1'b0, prq_req = 1'b0;
  logic reg_vld = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_err, irq_evq, irq_sync, stat_stray_ack, stat_unimpl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] m_err = '0, m_ack = '0;
  logic [1:0]  m_ctrl = '0;
  bit m_stray = 0, m_unimpl = 0;

  always #2 clk = ~clk;

  tae_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .raise_vld(raise_vld), .raise_mask(raise_mask),
    .evq_req(evq_req), .sync_req(sync_req), .prq_req(prq_req),
    .reg_vld(reg_vld), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_err(irq_err), .irq_evq(irq_evq), .irq_sync(irq_sync),
    .stat_stray_ack(stat_stray_ack), .stat_unimpl(stat_unimpl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_err;
      2'd1: return m_ack;
      2'd2: return {30'd0, m_ctrl};
      default: return 32'd0;
    endcase
  endfunction

  // One cycle: drive at negedge, check read data, clock, check pulses and flags.
  task automatic step(input bit rv, input logic [31:0] mask, input bit ev, input bit sy,
                      input bit pr, input bit vv, input bit wr, input logic [1:0] ad,
                      input logic [31:0] wd, input string tag);
    logic [31:0] fresh, n_err, pend_after;
    bit e_ierr, e_evq, e_sync;
    raise_vld = rv; raise_mask = mask; evq_req = ev; sync_req = sy; prq_req = pr;
    reg_vld = vv; reg_wr = wr; reg_addr = ad; reg_wdata = wd;
    #1;
    if (vv && !wr) chk({tag, " R11 read"}, reg_rdata, m_read(ad));
    else chk("R11 idle rdata", reg_rdata, 32'd0);
    fresh  = mask & ~(m_err ^ m_ack);
    e_ierr = rv && (fresh != 0) && m_ctrl[0];
    n_err  = rv ? (m_err ^ fresh) : m_err;
    e_evq  = ev && m_ctrl[1];
    e_sync = sy;
    if (vv && wr && ad == 2'd1) begin
      pend_after = n_err ^ m_ack;
      if (((wd ^ m_ack) & ~pend_after) != 0) m_stray = 1;
      m_ack = wd;
    end
    if (vv && wr && ad == 2'd2) m_ctrl = wd[1:0];
    m_err = n_err;
    if (pr) m_unimpl = 1;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R4 irq_err"}, {31'd0, irq_err}, {31'd0, e_ierr});
    chk({tag, " R7 irq_evq"}, {31'd0, irq_evq}, {31'd0, e_evq});
    chk({tag, " R8 irq_sync"}, {31'd0, irq_sync}, {31'd0, e_sync});
    chk({tag, " R6 stray"}, {31'd0, stat_stray_ack}, {31'd0, m_stray});
    chk({tag, " R9 unimpl"}, {31'd0, stat_unimpl}, {31'd0, m_unimpl});
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    step(0, 0, 0, 0, 0, 1, 0, a, 0, tag);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d, input string tag);
    step(0, 0, 0, 0, 0, 1, 1, a, d, tag);
  endtask

  task automatic raise(input logic [31:0] m, input string tag);
    step(1, m, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq lines", {29'd0, irq_err, irq_evq, irq_sync}, 32'd0);
    chk("R1 flags", {30'd0, stat_stray_ack, stat_unimpl}, 32'd0);
    rd(2'd0, "R1 err"); rd(2'd1, "R1 ack"); rd(2'd2, "R1 ctrl");

    wr_reg(2'd2, 32'hFFFF_FFFF, "R11 ctrl write");
    rd(2'd2, "R11 ctrl masked");
    raise(32'h5, "R2 fresh raise");
    rd(2'd0, "R2 err after raise");
    raise(32'h7, "R2 partial overlap");
    rd(2'd0, "R2 err partial");
    raise(32'h1, "R3 all pending");
    rd(2'd0, "R3 err unchanged");
    wr_reg(2'd1, 32'h1, "R5 ack pending bit");
    rd(2'd1, "R5 ack readback");
    raise(32'h1, "R2 re-raise after ack");
    wr_reg(2'd0, 32'hFFFF_FFFF, "R5 err write ignored");
    rd(2'd0, "R5 err still");
    // R10: raise 0x8 and acknowledge it in the same cycle
    step(1, 32'h8, 0, 0, 0, 1, 1, 2'd1, 32'h9, "R10 same cycle");
    rd(2'd0, "R10 err"); rd(2'd1, "R10 ack");
    wr_reg(2'd1, 32'h109, "R6 stray toggle");
    rd(2'd1, "R6 ack stored");
    wr_reg(2'd2, 32'h0, "R4 disable all");
    raise(32'h1_0000, "R4 raise disabled");
    rd(2'd0, "R4 err updated");
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R7 evq disabled");
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, "R8 sync ignoring enables");
    wr_reg(2'd2, 32'h2, "R7 evq enable");
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R7 evq enabled");
    raise(32'h2_0000, "R4 err enable off");
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, "R9 prq");
    wr_reg(2'd3, 32'h1234, "R11 reserved write");
    rd(2'd3, "R11 reserved read");
    step(0, 0, 1, 1, 0, 0, 0, 0, 0, "R8 sync and evq");
    // Random mix against the model
    for (int i = 0; i < 400; i++) begin
      logic [31:0] m;
      m = 32'(1) << ($urandom % 6);
      if ($urandom % 2) m = m | (32'(1) << ($urandom % 6));
      step(($urandom % 3) == 0, m, ($urandom % 4) == 0, ($urandom % 5) == 0,
           ($urandom % 50) == 0, ($urandom % 2) == 0, ($urandom % 2) == 0,
           2'($urandom % 4), m_ack ^ (32'($urandom % 4) << ($urandom % 5)), "R2 random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule